// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers a bank of peripheral interrupt sources and a small group of non-maskable trap lines into one interrupt request for a processor core. Each peripheral source keeps a pending flag, an enable bit and a 3-bit user priority. A source with priority 0 is treated as off. Traps have no enable and always outrank the user levels. A two-tier arbiter picks the winner. It compares user (or trap) level first, and where levels are equal the lower vector index wins.

The winner is compared against the core's current execution level. A request is raised only when the winner is strictly higher. At the moment of the grant the block latches the winning vector index and its 24-bit handler-table address. The address is the table base plus twice the index, and the base is either the primary table or the alternate table, chosen by one control bit. The vector becomes valid a fixed number of cycles after the request. The core then answers with an acknowledge pulse, which records the acknowledged index and clears that source's pending flag.

Vector numbering puts the eight trap slots at indices 0 to 7 and peripheral source `i` at index `8 + i`.

Top module: `vecIntCtrl`

## Requirements
- R1: After reset no request and no valid vector are driven. Every enable, priority and pending flag is cleared, and the alternate-table bit is cleared. An event on an unconfigured source therefore raises nothing.
- R2: A pending source never requests while its enable bit is 0 or its priority is 0. Its flag stays latched, so it requests once both are set.
- R3: A request is raised only when the winning level is strictly greater than `cpuLevel`. An equal or lower level raises nothing.
- R4: Among pending peripheral sources, the higher user priority (1 to 7) wins regardless of index.
- R5: Between sources with equal priority, the lower vector index wins.
- R6: Trap slot `t` carries level `15 - t` and needs no enable. Only slots 0 to TRAP_IMPL-1 (default 0 to 4) are implemented, and events on the other slots are ignored.
- R7: Trap `t` has vector index `t` and source `i` has vector index `8 + i`. `vecAddr` equals base + 2 × `vecIdx`, where the primary base is 0x000004.
- R8: While the alternate-table bit is 1, the base is ALT_BASE (default 0x000100, just past a 126-entry primary table). Writing it back to 0 restores the primary base.
- R9: `vecValid` rises exactly 2 cycles after `irqReq` rises. `irqReq`, `vecIdx` and `vecAddr` hold steady until an accepted acknowledge.
- R10: An `ack` while `vecValid` is 1 drops `irqReq` and `vecValid` on the next cycle. It loads `ackVec` with the granted index and clears that flag, so the same vector does not return. An `ack` while `vecValid` is 0 is ignored.
- R11: A new event on a source in the same cycle as the accepted acknowledge of that source leaves its flag pending, so it requests again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcEvent | input | NUM_SRC | One-cycle event pulses that set peripheral pending flags |
| trapEvent | input | 8 | One-cycle event pulses that set trap pending flags |
| cfgWr | input | 1 | Write strobe for one source's enable and priority |
| cfgSel | input | SEL_W | Source number addressed by `cfgWr` |
| cfgEn | input | 1 | Enable value written |
| cfgPrio | input | 3 | Priority value written (0 = off) |
| altWr | input | 1 | Write strobe for the alternate-table bit |
| altVal | input | 1 | Alternate-table bit value |
| cpuLevel | input | 4 | Current execution level of the core |
| ack | input | 1 | Acknowledge pulse from the core |
| irqReq | output | 1 | Interrupt request to the core |
| vecValid | output | 1 | Vector index and address are valid |
| vecIdx | output | VEC_W | Granted vector index |
| vecAddr | output | 24 | Handler-table entry address for the granted vector |
| ackVec | output | VEC_W | Index of the most recently acknowledged vector |

## Verification
Two functions can land in the same cycle and must not be confused. One is the flag clear caused by an accepted acknowledge. The other is a fresh event arriving on that same source. The bench provokes this by pulsing `ack` and the source's event line on the same clock edge. It then judges the outcome from the ports: `irqReq` must drop for one cycle and then rise again with the same vector index, which shows that the new event survived the clear. An acknowledge placed in the cycle before the vector is valid is also provoked. The bench checks that it neither shortens the entry latency nor retracts the request.

// File: rtl/vecIntPkg.sv
package vecIntPkg;
  localparam int TRAP_SLOTS = 8;
  localparam int LVL_W      = 4;
  localparam int PRIO_W     = 3;
  localparam int ADDR_W     = 24;

  typedef struct packed {
    logic grant;
    logic clear;
  } ctlStrobe_t;
endpackage

// File: rtl/icDatapath.sv
module icDatapath
  import vecIntPkg::*;
#(
  parameter int NUM_SRC   = 16,
  parameter int TRAP_IMPL = 5,
  parameter int VEC_W     = 5,
  parameter int SEL_W     = 4,
  parameter logic [ADDR_W-1:0] PRI_BASE = 24'h000004,
  parameter logic [ADDR_W-1:0] ALT_BASE = 24'h000100
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_SRC-1:0]    srcEvent,
  input  logic [TRAP_SLOTS-1:0] trapEvent,
  input  logic                  cfgWr,
  input  logic [SEL_W-1:0]      cfgSel,
  input  logic                  cfgEn,
  input  logic [PRIO_W-1:0]     cfgPrio,
  input  logic                  altWr,
  input  logic                  altVal,
  input  ctlStrobe_t            strobe,
  output logic [LVL_W-1:0]      winLvl,
  output logic [VEC_W-1:0]      vecIdx,
  output logic [ADDR_W-1:0]     vecAddr,
  output logic [VEC_W-1:0]      ackVec
);
  localparam int NUM_VEC = TRAP_SLOTS + NUM_SRC;

  logic [LVL_W-1:0] lvl [NUM_VEC];
  logic [VEC_W-1:0] winIdx;
  logic             altSel;

  // trap slots: fixed level, no enable; unimplemented slots stay idle
  for (genvar t = 0; t < TRAP_SLOTS; t++) begin : gTrap
    if (t < TRAP_IMPL) begin : gImpl
      logic flagQ;
      logic clrHit;
      assign clrHit = strobe.clear && (vecIdx == VEC_W'(t));
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) flagQ <= 1'b0;
        else       flagQ <= trapEvent[t] | (flagQ & ~clrHit);
      end
      assign lvl[t] = flagQ ? LVL_W'(15 - t) : '0;
    end else begin : gNone
      assign lvl[t] = '0;
    end
  end

  // peripheral sources: flag, enable, priority
  for (genvar s = 0; s < NUM_SRC; s++) begin : gSrc
    logic              flagQ;
    logic              enQ;
    logic [PRIO_W-1:0] prioQ;
    logic              clrHit;
    assign clrHit = strobe.clear && (vecIdx == VEC_W'(TRAP_SLOTS + s));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        flagQ <= 1'b0;
        enQ   <= 1'b0;
        prioQ <= '0;
      end else begin
        flagQ <= srcEvent[s] | (flagQ & ~clrHit);
        if (cfgWr && cfgSel == SEL_W'(s)) begin
          enQ   <= cfgEn;
          prioQ <= cfgPrio;
        end
      end
    end
    assign lvl[TRAP_SLOTS + s] = (flagQ && enQ) ? {1'b0, prioQ} : '0;
  end

  // two-tier pick: highest level, ties to the lowest index
  always_comb begin
    winLvl = '0;
    winIdx = '0;
    for (int v = NUM_VEC - 1; v >= 0; v--) begin
      if (lvl[v] != '0 && lvl[v] >= winLvl) begin
        winLvl = lvl[v];
        winIdx = VEC_W'(v);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      altSel  <= 1'b0;
      vecIdx  <= '0;
      vecAddr <= '0;
      ackVec  <= '0;
    end else begin
      if (altWr) altSel <= altVal;
      if (strobe.grant) begin
        vecIdx  <= winIdx;
        vecAddr <= (altSel ? ALT_BASE : PRI_BASE) + (ADDR_W'(winIdx) << 1);
      end
      if (strobe.clear) ackVec <= vecIdx;
    end
  end
endmodule

// File: rtl/icControl.sv
module icControl
  import vecIntPkg::*;
#(
  parameter int ENTRY_LAT = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LVL_W-1:0] winLvl,
  input  logic [LVL_W-1:0] cpuLevel,
  input  logic             ack,
  output ctlStrobe_t       strobe,
  output logic             irqReq,
  output logic             vecValid
);
  localparam int CNT_W = $clog2(ENTRY_LAT + 1);

  logic [CNT_W-1:0] latCnt;

  assign strobe.grant = !irqReq && (winLvl > cpuLevel);
  assign strobe.clear = vecValid && ack;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqReq   <= 1'b0;
      vecValid <= 1'b0;
      latCnt   <= '0;
    end else if (strobe.grant) begin
      irqReq   <= 1'b1;
      vecValid <= 1'b0;
      latCnt   <= '0;
    end else if (strobe.clear) begin
      irqReq   <= 1'b0;
      vecValid <= 1'b0;
    end else if (irqReq && !vecValid) begin
      if (latCnt == CNT_W'(ENTRY_LAT - 1)) vecValid <= 1'b1;
      else                                 latCnt   <= latCnt + 1'b1;
    end
  end
endmodule

// File: rtl/vecIntCtrl.sv
module vecIntCtrl
  import vecIntPkg::*;
#(
  parameter int NUM_SRC   = 16,
  parameter int TRAP_IMPL = 5,
  parameter int ENTRY_LAT = 2,
  parameter logic [23:0] PRI_BASE = 24'h000004,
  parameter logic [23:0] ALT_BASE = 24'h000100,
  localparam int VEC_W = $clog2(TRAP_SLOTS + NUM_SRC),
  localparam int SEL_W = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcEvent,
  input  logic [7:0]         trapEvent,
  input  logic               cfgWr,
  input  logic [SEL_W-1:0]   cfgSel,
  input  logic               cfgEn,
  input  logic [2:0]         cfgPrio,
  input  logic               altWr,
  input  logic               altVal,
  input  logic [3:0]         cpuLevel,
  input  logic               ack,
  output logic               irqReq,
  output logic               vecValid,
  output logic [VEC_W-1:0]   vecIdx,
  output logic [23:0]        vecAddr,
  output logic [VEC_W-1:0]   ackVec
);
  ctlStrobe_t       strobe;
  logic [LVL_W-1:0] winLvl;

  icDatapath #(
    .NUM_SRC(NUM_SRC), .TRAP_IMPL(TRAP_IMPL), .VEC_W(VEC_W), .SEL_W(SEL_W),
    .PRI_BASE(PRI_BASE), .ALT_BASE(ALT_BASE)
  ) i_dp (
    .clk(clk), .rstN(rstN), .srcEvent(srcEvent), .trapEvent(trapEvent),
    .cfgWr(cfgWr), .cfgSel(cfgSel), .cfgEn(cfgEn), .cfgPrio(cfgPrio),
    .altWr(altWr), .altVal(altVal), .strobe(strobe), .winLvl(winLvl),
    .vecIdx(vecIdx), .vecAddr(vecAddr), .ackVec(ackVec)
  );

  icControl #(.ENTRY_LAT(ENTRY_LAT)) i_ctl (
    .clk(clk), .rstN(rstN), .winLvl(winLvl), .cpuLevel(cpuLevel), .ack(ack),
    .strobe(strobe), .irqReq(irqReq), .vecValid(vecValid)
  );
endmodule

// File: rtl/vecIntCtrlChk.sv
module vecIntCtrlChk #(
  parameter int VEC_W = 5,
  parameter logic [23:0] PRI_BASE = 24'h000004,
  parameter logic [23:0] ALT_BASE = 24'h000100
) (
  input logic             clk,
  input logic             rstN,
  input logic             ack,
  input logic             irqReq,
  input logic             vecValid,
  input logic [VEC_W-1:0] vecIdx,
  input logic [23:0]      vecAddr,
  input logic [VEC_W-1:0] ackVec
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rstN |-> !irqReq && !vecValid);

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq && !(vecValid && ack) |=> irqReq && $stable(vecIdx) && $stable(vecAddr));

  // R9
  valid_needs_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> irqReq);

  // R9
  no_early_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqReq) |-> !vecValid);

  // R10
  ack_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    vecValid && ack |=> !irqReq && !vecValid && ackVec == $past(vecIdx));

  // R7
  addr_form_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (vecAddr == PRI_BASE + (24'(vecIdx) << 1)) ||
               (vecAddr == ALT_BASE + (24'(vecIdx) << 1)));
endmodule

bind vecIntCtrl vecIntCtrlChk #(.VEC_W(VEC_W), .PRI_BASE(PRI_BASE), .ALT_BASE(ALT_BASE)) i_chk (
  .clk(clk), .rstN(rstN), .ack(ack), .irqReq(irqReq), .vecValid(vecValid),
  .vecIdx(vecIdx), .vecAddr(vecAddr), .ackVec(ackVec)
);

// File: tb/test_vecIntCtrl.sv
module test_vecIntCtrl;
  localparam int NSRC  = 16;
  localparam int VEC_W = 5;
  localparam int SEL_W = 4;
  localparam int PBASE = 'h000004;
  localparam int ABASE = 'h000100;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NSRC-1:0] srcEvent = '0;
  logic [7:0] trapEvent = '0;
  logic cfgWr = 1'b0;
  logic [SEL_W-1:0] cfgSel = '0;
  logic cfgEn = 1'b0;
  logic [2:0] cfgPrio = '0;
  logic altWr = 1'b0;
  logic altVal = 1'b0;
  logic [3:0] cpuLevel = '0;
  logic ack = 1'b0;
  logic irqReq, vecValid;
  logic [VEC_W-1:0] vecIdx, ackVec;
  logic [23:0] vecAddr;

  int checks = 0;
  int fails = 0;
  bit altOn = 1'b0;

  always #4 clk = ~clk;

  vecIntCtrl i_vecIntCtrl (
    .clk(clk), .rstN(rstN), .srcEvent(srcEvent), .trapEvent(trapEvent),
    .cfgWr(cfgWr), .cfgSel(cfgSel), .cfgEn(cfgEn), .cfgPrio(cfgPrio),
    .altWr(altWr), .altVal(altVal), .cpuLevel(cpuLevel), .ack(ack),
    .irqReq(irqReq), .vecValid(vecValid), .vecIdx(vecIdx), .vecAddr(vecAddr),
    .ackVec(ackVec)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0; srcEvent = '0; trapEvent = '0; cfgWr = 0; ack = 0;
    altWr = 0; cpuLevel = '0; altOn = 0;
    tick(2);
    rstN = 1'b1;
    tick(1);
  endtask

  task automatic cfgSrc(input int s, input bit en, input int p);
    cfgWr = 1; cfgSel = SEL_W'(s); cfgEn = en; cfgPrio = 3'(p);
    tick(1);
    cfgWr = 0;
  endtask

  task automatic setAlt(input bit v);
    altWr = 1; altVal = v; tick(1); altWr = 0; altOn = v;
  endtask

  task automatic pulseSrc(input int s);
    srcEvent[s] = 1'b1; tick(1); srcEvent = '0;
  endtask

  task automatic waitReq(output bit seen);
    seen = 0;
    for (int i = 0; i < 12; i++) begin
      if (irqReq) begin seen = 1; return; end
      tick(1);
    end
  endtask

  // wait for request, check vector, latency and hold, then acknowledge
  task automatic takeGrant(input int expIdx, input string req);
    bit seen;
    int base;
    base = altOn ? ABASE : PBASE;
    waitReq(seen);
    chk(seen, req, int'(irqReq), 1);
    chk(int'(vecIdx) == expIdx, req, int'(vecIdx), expIdx);
    chk(int'(vecAddr) == base + 2 * expIdx, "R7/R8 address", int'(vecAddr), base + 2 * expIdx);
    chk(!vecValid, "R9 valid early", int'(vecValid), 0);
    tick(1);
    chk(!vecValid && irqReq, "R9 valid after 1", int'(vecValid), 0);
    tick(1);
    chk(vecValid && irqReq && int'(vecIdx) == expIdx, "R9 valid after 2", int'(vecValid), 1);
    ack = 1; tick(1); ack = 0;
    chk(!irqReq && !vecValid, "R10 release", int'(irqReq), 0);
    chk(int'(ackVec) == expIdx, "R10 ackVec", int'(ackVec), expIdx);
  endtask

  initial begin
    bit seen;
    // R1: reset state and cleared configuration
    doReset();
    chk(!irqReq && !vecValid, "R1 reset outputs", int'(irqReq), 0);
    pulseSrc(3);
    tick(5);
    chk(!irqReq, "R1 unconfigured source", int'(irqReq), 0);

    // R2, R7, R8, R10: every source; alternate table for upper half
    for (int s = 0; s < NSRC; s++) begin
      doReset();
      if (s >= NSRC / 2) setAlt(1'b1);
      cfgSrc(s, 1'b0, 5);
      pulseSrc(s);
      tick(5);
      chk(!irqReq, "R2 enable clear", int'(irqReq), 0);
      cfgSrc(s, 1'b1, 0);
      tick(5);
      chk(!irqReq, "R2 priority zero", int'(irqReq), 0);
      cfgSrc(s, 1'b1, (s % 7) + 1);
      takeGrant(8 + s, "R2 latched flag requests");
      tick(5);
      chk(!irqReq, "R10 flag cleared", int'(irqReq), 0);
    end

    // R8: back to primary base
    doReset();
    setAlt(1'b1);
    setAlt(1'b0);
    cfgSrc(2, 1'b1, 4);
    pulseSrc(2);
    takeGrant(10, "R8 primary restored");

    // R3: level against cpuLevel
    for (int p = 1; p <= 7; p++) begin
      for (int l = 0; l <= 7; l++) begin
        doReset();
        cfgSrc(5, 1'b1, p);
        cpuLevel = 4'(l);
        pulseSrc(5);
        tick(5);
        chk(irqReq == (p > l), "R3 strict compare", int'(irqReq), int'(p > l));
      end
    end

    // R4, R5: pairs of sources
    for (int a = 0; a < 8; a++) begin
      for (int b = a + 1; b < 8; b++) begin
        int pa, pb, win, lose;
        pa = (a * 3) % 7 + 1;
        pb = (b * 5) % 7 + 1;
        win  = (pb > pa) ? b : a;
        lose = (win == a) ? b : a;
        doReset();
        cfgSrc(a, 1'b1, pa);
        cfgSrc(b, 1'b1, pb);
        srcEvent[a] = 1'b1; srcEvent[b] = 1'b1; tick(1); srcEvent = '0;
        takeGrant(8 + win, pa == pb ? "R5 tie to lower index" : "R4 higher priority");
        takeGrant(8 + lose, "R4 remaining source");
      end
    end

    // R6: traps in slot order, unimplemented slots ignored
    doReset();
    cpuLevel = 4'd8;
    cfgSrc(0, 1'b1, 7);
    trapEvent = 8'hFF; pulseSrc(0); trapEvent = '0;
    for (int t = 0; t < 5; t++) takeGrant(t, "R6 trap order");
    tick(5);
    chk(!irqReq, "R6 unimplemented traps", int'(irqReq), 0);
    cpuLevel = 4'd0;
    takeGrant(8, "R6 source after traps");
    doReset();
    cfgSrc(1, 1'b1, 7);
    trapEvent[3] = 1'b1; pulseSrc(1); trapEvent = '0;
    takeGrant(3, "R6 trap beats priority 7");
    takeGrant(9, "R6 source follows trap");

    // R10: early acknowledge ignored
    doReset();
    cfgSrc(4, 1'b1, 3);
    pulseSrc(4);
    waitReq(seen);
    chk(seen && !vecValid, "R10 request up", int'(irqReq), 1);
    ack = 1; tick(1); ack = 0;
    chk(irqReq && !vecValid, "R10 early ack ignored", int'(irqReq), 1);
    tick(1);
    chk(irqReq && vecValid && vecIdx == 12, "R10 valid on time", int'(vecValid), 1);

    // R11: event collides with acknowledge of the same source
    ack = 1; srcEvent[4] = 1'b1; tick(1); ack = 0; srcEvent = '0;
    chk(!irqReq, "R11 release", int'(irqReq), 0);
    takeGrant(12, "R11 new event kept");
    tick(5);
    chk(!irqReq, "R11 single extra request", int'(irqReq), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule